// File: doc/BRIEF.md
# Dual-Channel Interval Timer

This block holds two independent 16-bit up-counting timer channels. Both channels are clocked from one functional clock, and each channel has its own register bank on a simple synchronous bus. A channel is set up by writing a terminal value and a control word. The control word selects a power-of-two prescale, one-shot or auto-reload operation, and interrupt masking. Once started, the count climbs by one on every prescaled tick. When the count matches the terminal value, the channel wraps to zero and latches an expiry flag. In one-shot operation it also stops itself.

Software typically uses one channel as a free-running time base, with the full 16-bit terminal value and auto-reload. It programs the other channel, one-shot and interrupt enabled, for the next event deadline. The expiry flag is sticky and is cleared by writing one to it. Each channel drives its own interrupt line.

Top module: `dtmr_top`

## Requirements
- R1: After reset, every register reads 0 and both interrupt outputs are low.
- R2: Channel n has its bank at byte address 0x80 + n*0x80. Within the bank, control is at +0x0, status at +0x4, terminal value at +0x8 and count at +0xC. Control reads back interrupt enable at bit 8, run at bit 5, one-shot at bit 4 and the prescale code at bits [3:0], with all other bits 0. Status reads its flag at bit 0. Any other address reads 0.
- R3: A control write that sets run while the channel is stopped clears the count to 0. With prescale code c (0 to 8), the count then rises by one 2^c clock edges after that write edge, and again every 2^c edges.
- R4: A tick that finds the count equal to the terminal value L returns the count to 0 and sets the status flag. The first expiry therefore lands (L+1)*2^c edges after the start. With one-shot clear the channel keeps running, and L = 0xFFFF gives a 65536-tick period.
- R5: With one-shot set, an expiry clears the run bit and the count stays at 0 until run is written again.
- R6: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R7: A channel's interrupt output is high exactly when its status flag and its interrupt-enable bit are both set.
- R8: A control write that clears run freezes the count at its current value. Restarting clears the count and restarts the prescaler.
- R9: Writes to the count register are ignored.
- R10: Activity on one channel never changes the other channel's count, flag or interrupt.
- R11: Prescale codes 9 to 15 divide by 256, the same as code 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock shared by both channels |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 2 | Per-channel interrupt, bit n for channel n |

## Verification
Any slip in the prescale divider or the count comparison shows up on the first expiry. The interrupt then rises one or more edges too early or too late, so the bench times every expiry to the exact edge. It also reads the count back on every edge of each run, which exposes a wrong step or a missed wrap within a single tick. A wrongly kept run bit after a one-shot expiry, or a count that moves while stopped, shows up in the readback a few cycles later. A flag that sets or clears wrongly is seen directly on the interrupt line.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
   // control word bit positions (decoded by software; positions are fixed)
   localparam int IE_BIT  = 8;
   localparam int RUN_BIT = 5;
   localparam int OS_BIT  = 4;
   localparam int CODE_W  = 4;

   // register offsets inside a channel bank
   localparam int OFF_CTRL = 'h0;
   localparam int OFF_STAT = 'h4;
   localparam int OFF_TERM = 'h8;
   localparam int OFF_CNT  = 'hC;

   typedef struct packed {
      logic              ie;
      logic              run;
      logic              oneshot;
      logic [CODE_W-1:0] code;
   } ctrl_t;

   typedef enum int unsigned {
      SEL_CTRL = 0,
      SEL_STAT = 1,
      SEL_TERM = 2,
      SEL_CNT  = 3
   } reg_sel_e;
endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler
   import dtmr_pkg::*;
#(
   parameter int MAX_CODE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   localparam int TOP_CODE = (1 << CODE_W) - 1;

   if (MAX_CODE < 1 || MAX_CODE > TOP_CODE) begin : g_bad_max
      $error("dtmr_prescaler: MAX_CODE out of range");
   end

   logic [CODE_W-1:0]   eff_code;
   logic [MAX_CODE-1:0] div_q;
   logic [MAX_CODE-1:0] mask;

   // variant: clamp only when the code field can exceed the deepest divider
   if (MAX_CODE == TOP_CODE) begin : g_noclamp
      assign eff_code = code;
   end else begin : g_clamp
      assign eff_code = (32'(code) > MAX_CODE) ? CODE_W'(MAX_CODE) : code;
   end

   for (genvar b = 0; b < MAX_CODE; b++) begin : g_mask
      assign mask[b] = (32'(eff_code) > b);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      div_q <= '0;
      else if (!run)   div_q <= '0;
      else             div_q <= div_q + MAX_CODE'(1);
   end

   assign tick = run && ((div_q & mask) == mask);

   // R3: a stopped divider never ticks and restarts from zero
   a_r3_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (div_q == '0))
      else $error("a_r3_div_idle");
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
   import dtmr_pkg::*;
#(
   parameter int CW       = 16,
   parameter int MAX_CODE = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    sel,
   input  logic          we,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] rdata,
   output logic          irq
);
   if (CW <= IE_BIT) begin : g_bad_cw
      $error("dtmr_channel: CW too narrow for the control word");
   end

   ctrl_t         ctrl_q;
   logic          flag_q;
   logic [CW-1:0] term_q;
   logic [CW-1:0] cnt_q;
   logic          tick;
   logic          wr_ctrl, wr_stat, wr_term;
   logic          start, expire;

   assign wr_ctrl = we && sel[SEL_CTRL];
   assign wr_stat = we && sel[SEL_STAT];
   assign wr_term = we && sel[SEL_TERM];
   // count-register writes are deliberately not decoded (R9)

   assign start  = wr_ctrl && wdata[RUN_BIT] && !ctrl_q.run;
   assign expire = ctrl_q.run && tick && (cnt_q == term_q);

   dtmr_prescaler #(.MAX_CODE(MAX_CODE)) u_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ctrl_q.run),
      .code (ctrl_q.code),
      .tick (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         flag_q <= 1'b0;
         term_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.ie      <= wdata[IE_BIT];
            ctrl_q.run     <= wdata[RUN_BIT];
            ctrl_q.oneshot <= wdata[OS_BIT];
            ctrl_q.code    <= wdata[CODE_W-1:0];
         end else if (expire && ctrl_q.oneshot) begin
            ctrl_q.run <= 1'b0;
         end

         if (wr_term) term_q <= wdata;

         if (start || expire)          cnt_q <= '0;
         else if (ctrl_q.run && tick)  cnt_q <= cnt_q + CW'(1);

         if (expire)                     flag_q <= 1'b1;
         else if (wr_stat && wdata[0])   flag_q <= 1'b0;
      end
   end

   logic [CW-1:0] ctrl_word;
   always_comb begin
      ctrl_word                = '0;
      ctrl_word[IE_BIT]        = ctrl_q.ie;
      ctrl_word[RUN_BIT]       = ctrl_q.run;
      ctrl_word[OS_BIT]        = ctrl_q.oneshot;
      ctrl_word[CODE_W-1:0]    = ctrl_q.code;
   end

   always_comb begin
      rdata = '0;
      if (sel[SEL_CTRL]) rdata = rdata | ctrl_word;
      if (sel[SEL_STAT]) rdata = rdata | CW'(flag_q);
      if (sel[SEL_TERM]) rdata = rdata | term_q;
      if (sel[SEL_CNT])  rdata = rdata | cnt_q;
   end

   assign irq = flag_q && ctrl_q.ie;

   // R3: a counting tick below the terminal value steps by exactly one
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.run && tick && (cnt_q != term_q)) |=> (cnt_q == $past(cnt_q) + CW'(1)))
      else $error("a_r3_step");
   // R4: expiry wraps the count
   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cnt_q == '0))
      else $error("a_r4_wrap");
   // R5: one-shot expiry stops the channel unless software rewrites control
   a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctrl_q.oneshot && !wr_ctrl) |=> !ctrl_q.run)
      else $error("a_r5_oneshot_stop");
   // R6: expiry always leaves the flag set, clear wins only without expiry
   a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag_q)
      else $error("a_r6_flag_set");
   a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wdata[0] && !expire) |=> !flag_q)
      else $error("a_r6_flag_clear");
   // R8: a stopped count holds
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.run && !start) |=> $stable(cnt_q))
      else $error("a_r8_hold");
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
   import dtmr_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int CW          = 16,
   parameter int ADDR_W      = 10,
   parameter int BANK_BASE   = 'h80,
   parameter int BANK_STRIDE = 'h80,
   parameter int MAX_CODE    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [CW-1:0]     bus_wdata,
   output logic [CW-1:0]     bus_rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int LAST_ADDR = BANK_BASE + (NUM_CH - 1) * BANK_STRIDE + OFF_CNT;

   if (NUM_CH < 1) begin : g_bad_nch
      $error("dtmr_top: NUM_CH must be at least 1");
   end
   if (BANK_STRIDE <= OFF_CNT) begin : g_bad_stride
      $error("dtmr_top: banks overlap");
   end
   if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("dtmr_top: ADDR_W too small for the bank layout");
   end

   logic [3:0]    sel    [NUM_CH];
   logic [CW-1:0] ch_rd  [NUM_CH];
   logic [NUM_CH-1:0] ch_hit;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam int BASE = BANK_BASE + i * BANK_STRIDE;

      assign sel[i][SEL_CTRL] = (bus_addr == ADDR_W'(BASE + OFF_CTRL));
      assign sel[i][SEL_STAT] = (bus_addr == ADDR_W'(BASE + OFF_STAT));
      assign sel[i][SEL_TERM] = (bus_addr == ADDR_W'(BASE + OFF_TERM));
      assign sel[i][SEL_CNT]  = (bus_addr == ADDR_W'(BASE + OFF_CNT));
      assign ch_hit[i]        = |sel[i];

      dtmr_channel #(.CW(CW), .MAX_CODE(MAX_CODE)) u_chan (
         .clk  (clk),
         .rst_n(rst_n),
         .sel  (sel[i]),
         .we   (bus_we),
         .wdata(bus_wdata),
         .rdata(ch_rd[i]),
         .irq  (irq[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CH; i++) bus_rdata = bus_rdata | ch_rd[i];
   end

   // R2: decode and read mux agree that unmapped addresses read zero
   a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_hit == '0) |-> (bus_rdata == '0))
      else $error("a_r2_unmapped_zero");
   // R2: at most one register selected across all banks
   a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_hit))
      else $error("a_r2_one_select");
endmodule

// File: tb/dtmr_top_test.sv
module dtmr_top_test;
   localparam int IE = 'h100, RUN = 'h20, OS = 'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [1:0]  irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   dtmr_top uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   always #5 clk = ~clk;

   function automatic int a_ctrl(int ch); return 'h80 + ch * 'h80; endfunction
   function automatic int a_stat(int ch); return 'h84 + ch * 'h80; endfunction
   function automatic int a_term(int ch); return 'h88 + ch * 'h80; endfunction
   function automatic int a_cnt (int ch); return 'h8C + ch * 'h80; endfunction

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the write edge
   task automatic wr(int a, int d);
      bus_addr  = 10'(a);
      bus_wdata = 16'(d);
      bus_we    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(int a, output int d);
      bus_addr = 10'(a);
      #1;
      d = int'(bus_rdata);
   endtask

   // one timed run: code is what is written, eff the divider it must produce
   task automatic run_case(int ch, int code, int eff, int term, bit os);
      int v;
      int per;
      int n;
      per = (term + 1) << eff;
      wr(a_term(ch), term);
      wr(a_ctrl(ch), IE | RUN | (os ? OS : 0) | code);
      for (int k = 0; k < per; k++) begin
         rd(a_cnt(ch), v);
         chk("R3 count per tick", v, k >> eff);
         chk("R4 no early expiry", int'(irq[ch]), 0);
         @(negedge clk);
      end
      chk("R4 expiry edge", int'(irq[ch]), 1);
      rd(a_cnt(ch), v);
      chk("R4 wrap to zero", v, 0);
      chk("R10 other channel quiet", int'(irq[1 - ch]), 0);
      if (os) begin
         rd(a_ctrl(ch), v);
         chk("R5 run cleared", (v >> 5) & 1, 0);
         repeat (per + 2) @(negedge clk);
         rd(a_cnt(ch), v);
         chk("R5 count parked", v, 0);
      end else begin
         repeat (1 << eff) @(negedge clk);
         n = per + (1 << eff);
         rd(a_cnt(ch), v);
         chk("R4 auto-reload count", v, (n >> eff) % (term + 1));
         rd(a_ctrl(ch), v);
         chk("R4 still running", (v >> 5) & 1, 1);
      end
      wr(a_ctrl(ch), IE | code);
      wr(a_stat(ch), 0);
      chk("R6 write 0 keeps flag", int'(irq[ch]), 1);
      wr(a_stat(ch), 1);
      chk("R6 write 1 clears", int'(irq[ch]), 0);
      wr(a_ctrl(ch), 0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int v;
      int loads[4] = '{0, 1, 3, 6};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int ch = 0; ch < 2; ch++) begin
         rd(a_ctrl(ch), v); chk("R1 ctrl reset", v, 0);
         rd(a_stat(ch), v); chk("R1 stat reset", v, 0);
         rd(a_term(ch), v); chk("R1 term reset", v, 0);
         rd(a_cnt(ch), v);  chk("R1 count reset", v, 0);
      end
      chk("R1 irq reset", int'(irq), 0);

      // R2 map and readback
      wr(a_ctrl(1), 'hFFDF);
      rd(a_ctrl(1), v); chk("R2 ctrl readback", v, 'h011F);
      rd(a_ctrl(0), v); chk("R10 ch0 ctrl untouched", v, 0);
      wr(a_ctrl(1), 0);
      wr(a_term(0), 'hA5C3);
      rd(a_term(0), v); chk("R2 term readback", v, 'hA5C3);
      rd(a_term(1), v); chk("R10 ch1 term untouched", v, 0);
      foreach (loads[i]) begin
         rd(i * 4 + 2, v); chk("R2 unmapped low", v, 0);
      end
      rd('h00, v);  chk("R2 unmapped 0x00", v, 0);
      rd('h90, v);  chk("R2 unmapped 0x90", v, 0);
      rd('h180, v); chk("R2 unmapped 0x180", v, 0);
      rd('h8A, v);  chk("R2 unmapped 0x8A", v, 0);

      // sweep of codes, terminal values, modes and channels (R3 R4 R5 R6 R10)
      for (int ch = 0; ch < 2; ch++)
         for (int c = 0; c < 4; c++)
            foreach (loads[li])
               for (int os = 0; os < 2; os++)
                  run_case(ch, c, c, loads[li], bit'(os));

      // R11 codes 8 and above divide by 256
      run_case(0, 8, 8, 0, 1'b1);
      run_case(1, 9, 8, 0, 1'b1);
      run_case(0, 15, 8, 1, 1'b0);

      // R7 flag without enable keeps irq low
      wr(a_term(1), 2);
      wr(a_ctrl(1), RUN | OS);
      repeat (2) @(negedge clk);
      rd(a_stat(1), v); chk("R7 no flag yet", v, 0);
      @(negedge clk);
      rd(a_stat(1), v); chk("R7 flag set", v, 1);
      chk("R7 masked irq low", int'(irq[1]), 0);
      wr(a_ctrl(1), IE);
      chk("R7 unmask raises irq", int'(irq[1]), 1);
      wr(a_stat(1), 1);
      chk("R7 cleared irq", int'(irq[1]), 0);
      wr(a_ctrl(1), 0);

      // R8 hold and restart, R9 count write ignored
      wr(a_term(0), 100);
      wr(a_ctrl(0), IE | RUN | 1);
      repeat (20) @(negedge clk);
      wr(a_ctrl(0), IE | 1);
      rd(a_cnt(0), v); chk("R8 frozen value", v, 10);
      repeat (10) @(negedge clk);
      rd(a_cnt(0), v); chk("R8 still frozen", v, 10);
      wr(a_ctrl(0), IE | RUN | 1);
      rd(a_cnt(0), v); chk("R8 restart at zero", v, 0);
      @(negedge clk);
      rd(a_cnt(0), v); chk("R8 divider restarted", v, 0);
      @(negedge clk);
      rd(a_cnt(0), v); chk("R8 first tick", v, 1);
      wr(a_ctrl(0), 0);
      rd(a_cnt(0), v); chk("R8 stop count", v, 1);
      wr(a_cnt(0), 'h1234);
      rd(a_cnt(0), v); chk("R9 count write ignored", v, 1);

      // R4 full 16-bit period
      wr(a_term(0), 'hFFFF);
      wr(a_ctrl(0), IE | RUN | OS);
      repeat (65535) @(negedge clk);
      rd(a_cnt(0), v); chk("R4 full count top", v, 'hFFFF);
      chk("R4 full no early irq", int'(irq[0]), 0);
      @(negedge clk);
      chk("R4 full period expiry", int'(irq[0]), 1);
      rd(a_cnt(0), v); chk("R4 full wrap", v, 0);
      wr(a_stat(0), 1);
      chk("R6 final clear", int'(irq[0]), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule